// File: doc/BRIEF.md
# Audio Transmit Sample Queue

This block is a transmit sample queue that sits between a 32-bit register write port and an audio serializer. Software, or a DMA engine, writes 32-bit sample words into it one at a time. The serializer pulls them out in the order they were written. The queue always reports how many words it holds.

Two interrupt sources watch the queue, and each has its own enable:
- a low-water status that is high while the fill level is at or below a programmable threshold;
- a sticky underrun status that latches when the serializer asks for a word the queue cannot supply.

The underrun status stays set until software pulses a write-one acknowledge. A DMA request line, with its own enable and watermark, asks for refills.

A flush command empties the queue and resets its pointers. Its busy indication clears by itself once the queue is empty again. A transfer-start input decides whether the serializer's requests are honoured at all.

Top module: `aud_txq`

## Requirements
- R1: Words leave the queue on `ser_data` in exactly the order they were accepted. The queue holds up to DEPTH (default 32) words of DATA_W (default 32) bits.
- R2: `level` reports the number of stored words, from 0 to DEPTH, in a field of 6 bits at the defaults. It changes on the clock edge that accepts a push or a pop. A push and a pop in the same cycle leave `level` unchanged.
- R3: A write while `level` equals DEPTH is dropped. `level` stays at DEPTH and the stored words are unchanged.
- R4: While `xfer_start` is 0, `ser_req` has no effect: `level` does not change and no underrun is recorded.
- R5: A word is popped on the edge that ends a cycle with `ser_req`=1, `xfer_start`=1, `level`>0 and no flush in progress. During that cycle `ser_data` carries the oldest stored word.
- R6: `empty_stat` is 1 exactly when `level` is less than or equal to the 5-bit `empty_thr` value.
- R7: A request with `xfer_start`=1 while no word is available (`level`=0 or flush in progress) drives `ser_data` to 0. The same request sets `urun_stat` on the next edge.
- R8: `urun_stat` stays set until a cycle with `urun_ack`=1. A new underrun in the same cycle as the acknowledge wins, and the status stays set.
- R9: `irq` is 1 exactly when (`empty_stat` and `empty_ie`) or (`urun_stat` and `urun_ie`).
- R10: `dma_req` is 1 exactly when `dma_en`=1 and `level` is less than or equal to the 5-bit `dma_mark` value.
- R11: A one-cycle `flush_req` makes `flush_busy` read 1 for the next cycle. When `flush_busy` returns to 0 by itself, `level` is 0 and the next word written is the next word read. Writes and pops during `flush_busy` are ignored.
- R12: After reset, `level`=0, `urun_stat`=0, `flush_busy`=0 and `dma_req`=0 while `dma_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push strobe from the register write port |
| wr_data | input | DATA_W | Sample word to push |
| xfer_start | input | 1 | Transfer start; allows the serializer to consume words |
| ser_req | input | 1 | Serializer asks for a word in this cycle |
| ser_data | output | DATA_W | Oldest word, or 0 when none is available |
| empty_thr | input | THR_W | Low-water threshold |
| empty_ie | input | 1 | Low-water interrupt enable |
| urun_ie | input | 1 | Underrun interrupt enable |
| urun_ack | input | 1 | Write-one acknowledge for underrun |
| dma_en | input | 1 | DMA request enable |
| dma_mark | input | THR_W | DMA watermark |
| flush_req | input | 1 | Flush command pulse |
| level | output | LVL_W | Current fill level |
| empty_stat | output | 1 | Low-water status |
| urun_stat | output | 1 | Latched underrun status |
| flush_busy | output | 1 | Flush in progress |
| dma_req | output | 1 | DMA refill request |
| irq | output | 1 | Combined interrupt |

## Verification
The checker evaluates several properties on every cycle:
- the level bound;
- a full queue holding its level when no pop or flush occurs;
- the level freezing while transfer is stopped and nothing is written;
- zero data on a starved request;
- the underrun latch setting and staying sticky;
- a flush always ending one cycle later with an empty queue.

Only the directed scenarios can show some behaviours: word ordering across a wrap of the pointers, the exact threshold and watermark crossover points, the combining of the interrupt enables, and that the first word after a flush is read back correctly.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic {
      FL_IDLE  = 1'b0,
      FL_CLEAR = 1'b1
   } flush_st_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              clear,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] head_data,
   output logic [LVL_W-1:0]  level
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign head_data = mem[rd_ptr];
endmodule

// File: rtl/txq_flush.sv
module txq_flush (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_req,
   output logic busy,
   output logic clear
);
   import txq_pkg::*;
   flush_st_t st, st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         FL_IDLE:  if (flush_req) st_nx = FL_CLEAR;
         FL_CLEAR: st_nx = FL_IDLE;
         default:  st_nx = FL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= FL_IDLE;
      else        st <= st_nx;
   end

   assign busy  = (st == FL_CLEAR);
   assign clear = (st == FL_CLEAR);
endmodule

// File: rtl/txq_lecmp.sv
module txq_lecmp #(
   parameter int LVL_W = 6,
   parameter int THR_W = 5
) (
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   input  logic             en,
   output logic             hit
);
   assign hit = en && (level <= LVL_W'(thr));
endmodule

// File: rtl/txq_events.sv
module txq_events #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            urun_evt,
   input  logic            urun_ack,
   input  logic            low_stat,
   input  logic [NSRC-1:0] src_en,
   output logic            urun_stat,
   output logic            irq
);
   logic [NSRC-1:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        urun_stat <= 1'b0;
      else if (urun_evt) urun_stat <= 1'b1;
      else if (urun_ack) urun_stat <= 1'b0;
   end

   always_comb begin
      pend    = '0;
      pend[0] = low_stat;
      pend[1] = urun_stat;
   end

   assign irq = |(pend & src_en);
endmodule

// File: rtl/aud_txq.sv
module aud_txq #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer_start,
   input  logic              ser_req,
   output logic [DATA_W-1:0] ser_data,
   input  logic [THR_W-1:0]  empty_thr,
   input  logic              empty_ie,
   input  logic              urun_ie,
   input  logic              urun_ack,
   input  logic              dma_en,
   input  logic [THR_W-1:0]  dma_mark,
   input  logic              flush_req,
   output logic [LVL_W-1:0]  level,
   output logic              empty_stat,
   output logic              urun_stat,
   output logic              flush_busy,
   output logic              dma_req,
   output logic              irq
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("aud_txq: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("aud_txq: DATA_W must be positive");
   end

   logic              clear, push, pop, avail, want, urun_evt;
   logic [DATA_W-1:0] head;

   assign want     = ser_req && xfer_start;
   assign avail    = (level != '0) && !flush_busy;
   assign push     = wr_en && (level != LVL_W'(DEPTH)) && !flush_busy;
   assign pop      = want && avail;
   assign urun_evt = want && !avail;
   assign ser_data = avail ? head : '0;

   txq_flush u_flush (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush_req (flush_req),
      .busy      (flush_busy),
      .clear     (clear)
   );

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .clear     (clear),
      .wr_data   (wr_data),
      .head_data (head),
      .level     (level)
   );

   txq_lecmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_low (
      .level (level),
      .thr   (empty_thr),
      .en    (1'b1),
      .hit   (empty_stat)
   );

   txq_lecmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_dma (
      .level (level),
      .thr   (dma_mark),
      .en    (dma_en),
      .hit   (dma_req)
   );

   txq_events #(.NSRC(2)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .urun_evt  (urun_evt),
      .urun_ack  (urun_ack),
      .low_stat  (empty_stat),
      .src_en    ({urun_ie, empty_ie}),
      .urun_stat (urun_stat),
      .irq       (irq)
   );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int THR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              xfer_start,
   input logic              ser_req,
   input logic [DATA_W-1:0] ser_data,
   input logic              urun_ack,
   input logic              empty_ie,
   input logic              urun_ie,
   input logic              flush_req,
   input logic [LVL_W-1:0]  level,
   input logic              urun_stat,
   input logic              flush_busy,
   input logic              irq
);
   // R2: level never exceeds the capacity
   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R3: a full queue stays full unless a pop or a flush occurs
   a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LVL_W'(DEPTH) && !(ser_req && xfer_start) && !flush_req && !flush_busy)
      |=> level == LVL_W'(DEPTH));

   // R4: stopped transfer with no writes leaves the level alone
   a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_start && !wr_en && !flush_req && !flush_busy) |=> $stable(level));

   // R7: a starved request returns zero and sets the underrun status
   a_r7_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_req && xfer_start && level == '0) |-> ser_data == '0);
   a_r7_urun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_req && xfer_start && level == '0) |=> urun_stat);

   // R8: underrun is sticky until acknowledged
   a_r8_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (urun_stat && !urun_ack) |=> urun_stat);

   // R9: interrupt needs at least one enable
   a_r9_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (empty_ie || urun_ie));

   // R11: a flush completes in one cycle with an empty queue
   a_r11_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> (!flush_busy && level == '0));
endmodule

bind aud_txq txq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .xfer_start (xfer_start),
   .ser_req    (ser_req),
   .ser_data   (ser_data),
   .urun_ack   (urun_ack),
   .empty_ie   (empty_ie),
   .urun_ie    (urun_ie),
   .flush_req  (flush_req),
   .level      (level),
   .urun_stat  (urun_stat),
   .flush_busy (flush_busy),
   .irq        (irq)
);

// File: tb/tb_aud_txq.sv
module tb_aud_txq;
   localparam int DW = 32;
   localparam int DP = 32;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          wr_en = 0, xfer_start = 0, ser_req = 0;
   logic [DW-1:0] wr_data = '0, ser_data;
   logic [4:0]    empty_thr = '0, dma_mark = '0;
   logic          empty_ie = 0, urun_ie = 0, urun_ack = 0, dma_en = 0, flush_req = 0;
   logic [5:0]    level;
   logic          empty_stat, urun_stat, flush_busy, dma_req, irq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   aud_txq #(.DATA_W(DW), .DEPTH(DP)) dut (.*);

   always #10 clk = ~clk;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic push(logic [31:0] w);
      @(negedge clk); wr_en = 1; wr_data = w;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic pop_chk(string tag, logic [31:0] exp);
      @(negedge clk); ser_req = 1; #1;
      chk(tag, ser_data, exp);
      @(negedge clk); ser_req = 0;
   endtask

   task automatic t_reset();
      chk("R12 level", 32'(level), 0);
      chk("R12 urun", 32'(urun_stat), 0);
      chk("R12 busy", 32'(flush_busy), 0);
      chk("R12 dma", 32'(dma_req), 0);
      chk("R12 irq", 32'(irq), 0);
   endtask

   task automatic t_order();
      for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
      chk("R2 level5", 32'(level), 5);
      xfer_start = 1;
      for (int i = 0; i < 5; i++) pop_chk("R1 R5 order", 32'hA000_0000 + i);
      chk("R2 level0", 32'(level), 0);
   endtask

   task automatic t_full();
      xfer_start = 0;
      for (int i = 0; i < DP; i++) push(32'h1000 + i);
      chk("R2 full level", 32'(level), DP);
      push(32'hDEAD_BEEF);
      chk("R3 drop level", 32'(level), DP);
      // R4: request while stopped does nothing
      @(negedge clk); ser_req = 1;
      @(negedge clk); @(negedge clk); ser_req = 0;
      chk("R4 stopped level", 32'(level), DP);
      chk("R4 no urun", 32'(urun_stat), 0);
      xfer_start = 1;
      for (int i = 0; i < DP; i++) pop_chk("R3 R1 contents", 32'h1000 + i);
      chk("R2 drained", 32'(level), 0);
   endtask

   task automatic t_simul();
      push(32'h55);
      @(negedge clk); wr_en = 1; wr_data = 32'h66; ser_req = 1; #1;
      chk("R5 head", ser_data, 32'h55);
      @(negedge clk); wr_en = 0; ser_req = 0;
      chk("R2 push+pop", 32'(level), 1);
      pop_chk("R1 after simul", 32'h66);
   endtask

   task automatic t_thresh();
      empty_thr = 5'd3; empty_ie = 0; xfer_start = 0;
      for (int i = 0; i < 4; i++) push(i);
      chk("R6 above", 32'(empty_stat), 0);
      empty_ie = 1; #1;
      chk("R9 no irq above", 32'(irq), 0);
      xfer_start = 1;
      pop_chk("R1 thr pop", 0);
      chk("R6 at thr", 32'(empty_stat), 1);
      chk("R9 irq low", 32'(irq), 1);
      empty_ie = 0; #1;
      chk("R9 masked", 32'(irq), 0);
      for (int i = 1; i < 4; i++) pop_chk("R1 thr drain", i);
   endtask

   task automatic t_urun();
      empty_thr = '0; urun_ie = 0;
      @(negedge clk); ser_req = 1; #1;
      chk("R7 zero data", ser_data, 0);
      @(negedge clk); ser_req = 0;
      chk("R7 urun set", 32'(urun_stat), 1);
      @(negedge clk); @(negedge clk);
      chk("R8 sticky", 32'(urun_stat), 1);
      chk("R9 urun masked", 32'(irq), 0);
      urun_ie = 1; #1;
      chk("R9 urun irq", 32'(irq), 1);
      @(negedge clk); urun_ack = 1;
      @(negedge clk); urun_ack = 0;
      chk("R8 ack clears", 32'(urun_stat), 0);
      // set beats ack in the same cycle
      @(negedge clk); urun_ack = 1; ser_req = 1;
      @(negedge clk); urun_ack = 0; ser_req = 0;
      chk("R8 set wins", 32'(urun_stat), 1);
      @(negedge clk); urun_ack = 1;
      @(negedge clk); urun_ack = 0; urun_ie = 0;
   endtask

   task automatic t_dma();
      xfer_start = 0; dma_mark = 5'd2; dma_en = 1;
      for (int i = 0; i < 3; i++) push(i);
      chk("R10 above mark", 32'(dma_req), 0);
      xfer_start = 1;
      pop_chk("R1 dma pop", 0);
      chk("R10 at mark", 32'(dma_req), 1);
      dma_en = 0; #1;
      chk("R10 disabled", 32'(dma_req), 0);
      for (int i = 1; i < 3; i++) pop_chk("R1 dma drain", i);
   endtask

   task automatic t_flush();
      xfer_start = 0;
      for (int i = 0; i < 10; i++) push(32'hF0 + i);
      @(negedge clk); flush_req = 1;
      @(negedge clk); flush_req = 0;
      chk("R11 busy", 32'(flush_busy), 1);
      wr_en = 1; wr_data = 32'hBAD;
      @(negedge clk); wr_en = 0;
      chk("R11 done", 32'(flush_busy), 0);
      chk("R11 empty", 32'(level), 0);
      push(32'hA5);
      chk("R11 level1", 32'(level), 1);
      xfer_start = 1;
      pop_chk("R11 first after", 32'hA5);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         finish_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_order();
      t_full();
      t_simul();
      t_thresh();
      t_urun();
      t_dma();
      t_flush();
      finish_up();
   end
endmodule